// File: doc/BRIEF.md
# Switch Port Error Collector and Interrupt Registers

This block gathers per-port fault events of a multi-port serial switch into four sticky error vectors: clock fault, data-recovery fault, threshold fault and link fault. Each vector has one bit per port. A host reaches the vectors over a byte-wide register bus with a 6-bit address. Each vector is read as a low byte followed by a high byte, and a read empties exactly the byte it returns.

A control register sets two things for each fault class. An interrupt-enable bit lets the class pull the active-low interrupt line. An automatic-reinitialise enable bit makes the class raise a one-cycle restart request for every port whose fault bit newly sets. A read-only summary register shows which classes hold any set bit. A third register holds a self-test enable and a 4-bit cell clock delay, and drives both straight out to the rest of the switch.

Top module: `err_irq_regs`

## Requirements
- R1: Address 0 is read-only and reports one summary bit per class: bit 3 is the clock class, bit 2 data-recovery, bit 1 threshold and bit 0 link. Each bit is 1 when any port bit of that class is set. Bits 7..4 read 0.
- R2: Address 1 is a read/write control byte. Bits 7/6/5/4 are the restart enables for the clock/data-recovery/threshold/link classes. Bits 3/2/1/0 are the interrupt enables for the same classes in the same order.
- R3: `irqN` is 0 while any class whose interrupt enable is set holds a set port bit, and is 1 otherwise.
- R4: When a port bit of a class goes from 0 to 1 while that class's restart enable is set, `reinitReq` for that port is 1 for exactly one cycle. That cycle is the one right after the event is captured.
- R5: An event bit on port p of a class sets bit p of that class's sticky vector, and the bit stays set until read. The low/high byte pairs sit at addresses 4/5 (clock), 6/7 (data-recovery), 8/9 (threshold) and 10/11 (link).
- R6: A read of an error byte clears only that byte. The other byte of the same vector and all other vectors are unchanged.
- R7: Address 2 is read/write. Bit 4 drives `bistEn` and bits 3..0 drive `cellDelay`. The other bits read 0.
- R8: Reset clears every register: `irqN` is 1, `reinitReq` is 0, and all readable bytes are 0.
- R9: An event that arrives in the same cycle as a read clearing its byte remains set after that read.
- R10: Writes to addresses 0 and 4..11 change nothing. Reads of addresses 3 and 12..63 return 0.
- R11: Read data appears on `rdData` in the cycle after `rdEn` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 6 | Register address |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Registered read data |
| clkErrIn | input | 16 | Clock fault events, one per port |
| druErrIn | input | 16 | Data-recovery fault events |
| thrErrIn | input | 16 | Threshold fault events |
| lnkErrIn | input | 16 | Link fault events |
| irqN | output | 1 | Active-low interrupt |
| reinitReq | output | 16 | Per-port restart pulse |
| bistEn | output | 1 | Self-test enable |
| cellDelay | output | 4 | Cell clock delay |

## Verification
The bench builds the block with its defaults: 16 ports, a 6-bit address and an 8-bit data bus. With these values every vector spans exactly two bytes. That brings the low/high clear split within reach, along with events on ports in both halves. The address space also keeps unmapped locations both below and above the error bytes, so reads of both ranges can be tried.

// File: rtl/err_irq_pkg.sv
package err_irq_pkg;
  localparam int NUM_CLASS = 4;
  localparam int ADDR_STATUS = 0;
  localparam int ADDR_IRQCTL = 1;
  localparam int ADDR_MISC   = 2;
  localparam int ADDR_ERRBASE = 4;

  typedef struct packed {
    logic wrIrqCtl;
    logic wrMisc;
    logic rdStatus;
    logic rdIrqCtl;
    logic rdMisc;
    logic rdErr;
  } regStrobe_t;
endpackage

// File: rtl/err_irq_ctrl.sv
module err_irq_ctrl
  import err_irq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int ERR_BYTES = 2,
  localparam int TOT_BYTES = NUM_CLASS * ERR_BYTES,
  localparam int IDX_W = $clog2(TOT_BYTES)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output regStrobe_t        strb,
  output logic [IDX_W-1:0]  errIdx
);
  logic [ADDR_W-1:0] offset;
  logic errHit;

  always_comb begin
    offset = addr - ADDR_W'(ADDR_ERRBASE);
    errHit = (addr >= ADDR_W'(ADDR_ERRBASE)) &&
             (addr <  ADDR_W'(ADDR_ERRBASE + TOT_BYTES));
    errIdx = offset[IDX_W-1:0];
    strb.wrIrqCtl = wrEn && (addr == ADDR_W'(ADDR_IRQCTL));
    strb.wrMisc   = wrEn && (addr == ADDR_W'(ADDR_MISC));
    strb.rdStatus = rdEn && (addr == ADDR_W'(ADDR_STATUS));
    strb.rdIrqCtl = rdEn && (addr == ADDR_W'(ADDR_IRQCTL));
    strb.rdMisc   = rdEn && (addr == ADDR_W'(ADDR_MISC));
    strb.rdErr    = rdEn && errHit;
  end

  // R10: read strobes are mutually exclusive
  always_comb begin
    p_one_read_target_r10: assert ($onehot0({strb.rdStatus, strb.rdIrqCtl, strb.rdMisc, strb.rdErr}))
      else $error("p_one_read_target_r10");
  end
endmodule

// File: rtl/err_irq_dpath.sv
module err_irq_dpath
  import err_irq_pkg::*;
#(
  parameter int PORTS = 16,
  parameter int DATA_W = 8,
  localparam int ERR_BYTES = PORTS / DATA_W,
  localparam int TOT_BYTES = NUM_CLASS * ERR_BYTES,
  localparam int IDX_W = $clog2(TOT_BYTES)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  regStrobe_t                      strb,
  input  logic [IDX_W-1:0]                errIdx,
  input  logic                            rdEn,
  input  logic [DATA_W-1:0]               wrData,
  input  logic [NUM_CLASS-1:0][PORTS-1:0] errIn,
  output logic [DATA_W-1:0]               rdData,
  output logic                            irqN,
  output logic [PORTS-1:0]                reinitReq,
  output logic                            bistEn,
  output logic [3:0]                      cellDelay
);
  logic [NUM_CLASS-1:0][PORTS-1:0] errQ, errPrev, clrMask;
  logic [7:0] irqCtl;
  logic [3:0] classAny;
  logic [DATA_W-1:0] rdMux;
  logic [NUM_CLASS*PORTS-1:0] errFlat;

  assign errFlat = errQ;

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
    assign classAny[NUM_CLASS-1-c] = |errQ[c];
    for (genvar b = 0; b < ERR_BYTES; b++) begin : g_byte
      assign clrMask[c][b*DATA_W +: DATA_W] =
        {DATA_W{strb.rdErr && (errIdx == IDX_W'(c*ERR_BYTES + b))}};

      // R6: a cleared byte with no new events reads back empty
      p_clear_byte_r6: assert property (@(posedge clk) disable iff (!rstN)
        (strb.rdErr && errIdx == IDX_W'(c*ERR_BYTES + b) && errIn[c][b*DATA_W +: DATA_W] == '0)
        |=> errQ[c][b*DATA_W +: DATA_W] == '0)
        else $error("p_clear_byte_r6");
    end

    // R9: every arriving event is held in the following cycle
    p_no_lost_event_r9: assert property (@(posedge clk) disable iff (!rstN)
      (errIn[c] != '0) |=> ((errQ[c] & $past(errIn[c])) == $past(errIn[c])))
      else $error("p_no_lost_event_r9");
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errQ <= '0;
      errPrev <= '0;
      irqCtl <= '0;
      bistEn <= 1'b0;
      cellDelay <= '0;
      rdData <= '0;
    end else begin
      errQ <= (errQ & ~clrMask) | errIn;
      errPrev <= errQ;
      if (strb.wrIrqCtl) irqCtl <= wrData[7:0];
      if (strb.wrMisc) begin
        bistEn <= wrData[4];
        cellDelay <= wrData[3:0];
      end
      if (rdEn) rdData <= rdMux;
    end
  end

  always_comb begin
    rdMux = '0;
    if (strb.rdStatus) rdMux[3:0] = classAny;
    if (strb.rdIrqCtl) rdMux[7:0] = irqCtl;
    if (strb.rdMisc)   rdMux[4:0] = {bistEn, cellDelay};
    if (strb.rdErr)    rdMux = errFlat[errIdx*DATA_W +: DATA_W];
  end

  assign irqN = ~|(irqCtl[3:0] & classAny);

  always_comb begin
    reinitReq = '0;
    for (int c = 0; c < NUM_CLASS; c++)
      reinitReq |= {PORTS{irqCtl[7-c]}} & errQ[c] & ~errPrev[c];
  end

  // R4: a restart request lasts a single cycle
  p_reinit_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reinitReq != '0) |=> ((reinitReq & $past(reinitReq)) == '0))
    else $error("p_reinit_single_r4");

  // R3: the interrupt line is only pulled when some class is enabled
  p_irq_needs_enable_r3: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> (irqCtl[3:0] != 4'd0))
    else $error("p_irq_needs_enable_r3");
endmodule

// File: rtl/err_irq_regs.sv
module err_irq_regs
  import err_irq_pkg::*;
#(
  parameter int PORTS = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  localparam int ERR_BYTES = PORTS / DATA_W,
  localparam int IDX_W = $clog2(NUM_CLASS * ERR_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic [PORTS-1:0]  clkErrIn,
  input  logic [PORTS-1:0]  druErrIn,
  input  logic [PORTS-1:0]  thrErrIn,
  input  logic [PORTS-1:0]  lnkErrIn,
  output logic              irqN,
  output logic [PORTS-1:0]  reinitReq,
  output logic              bistEn,
  output logic [3:0]        cellDelay
);
  regStrobe_t strb;
  logic [IDX_W-1:0] errIdx;
  logic [NUM_CLASS-1:0][PORTS-1:0] errIn;

  assign errIn = {lnkErrIn, thrErrIn, druErrIn, clkErrIn};

  err_irq_ctrl #(.ADDR_W(ADDR_W), .ERR_BYTES(ERR_BYTES)) u_ctrl (
    .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .strb(strb), .errIdx(errIdx)
  );

  err_irq_dpath #(.PORTS(PORTS), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .errIdx(errIdx), .rdEn(rdEn),
    .wrData(wrData), .errIn(errIn), .rdData(rdData), .irqN(irqN),
    .reinitReq(reinitReq), .bistEn(bistEn), .cellDelay(cellDelay)
  );
endmodule

// File: tb/err_irq_regs_tb.sv
module err_irq_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic [5:0] addr = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [15:0] clkErrIn = '0, druErrIn = '0, thrErrIn = '0, lnkErrIn = '0;
  logic irqN, bistEn;
  logic [15:0] reinitReq;
  logic [3:0] cellDelay;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  err_irq_regs u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .clkErrIn(clkErrIn), .druErrIn(druErrIn),
    .thrErrIn(thrErrIn), .lnkErrIn(lnkErrIn), .irqN(irqN),
    .reinitReq(reinitReq), .bistEn(bistEn), .cellDelay(cellDelay)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic regWrite(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0; d = rdData;
  endtask

  // one-cycle event; returns reinitReq in the cycle after capture
  task automatic pulseEvt(input logic [15:0] c, input logic [15:0] d,
                          input logic [15:0] t, input logic [15:0] l,
                          output logic [15:0] req);
    @(negedge clk); clkErrIn = c; druErrIn = d; thrErrIn = t; lnkErrIn = l;
    @(negedge clk); req = reinitReq;
    clkErrIn = '0; druErrIn = '0; thrErrIn = '0; lnkErrIn = '0;
  endtask

  task automatic testReset();
    logic [7:0] d;
    check("R8 irqN", irqN, 1);
    check("R8 reinitReq", reinitReq, 0);
    check("R8 bistEn", bistEn, 0);
    check("R8 cellDelay", cellDelay, 0);
    regRead(6'd1, d); check("R8 irqctl", d, 0);
    regRead(6'd0, d); check("R8 status", d, 0);
  endtask

  task automatic testCtlRegs();
    logic [7:0] d;
    regWrite(6'd1, 8'h0F); regRead(6'd1, d); check("R2 irqctl rw", d, 8'h0F);
    regWrite(6'd2, 8'hFA);
    check("R7 bistEn", bistEn, 1);
    check("R7 cellDelay", cellDelay, 4'hA);
    regRead(6'd2, d); check("R7 misc readback", d, 8'h1A);
  endtask

  task automatic testCaptureAndIrq();
    logic [7:0] d; logic [15:0] r;
    pulseEvt(16'h0008, 0, 0, 0, r);
    check("R3 irqN low", irqN, 0);
    regRead(6'd0, d); check("R1 status clk", d, 8'h08);
    regRead(6'd4, d); check("R5 clk lsb", d, 8'h08);
    regRead(6'd4, d); check("R6 cleared", d, 8'h00);
    check("R3 irqN released", irqN, 1);
    pulseEvt(0, 0, 16'h0200, 16'h0001, r);
    regRead(6'd0, d); check("R1 status thr+lnk", d, 8'h03);
    regRead(6'd8, d); check("R5 thr lsb empty", d, 8'h00);
    regRead(6'd9, d); check("R6 msb kept", d, 8'h02);
    regRead(6'd9, d); check("R6 msb cleared", d, 8'h00);
    regRead(6'd10, d); check("R5 lnk lsb", d, 8'h01);
    regRead(6'd0, d); check("R1 status empty", d, 8'h00);
  endtask

  task automatic testReinit();
    logic [7:0] d; logic [15:0] r;
    regWrite(6'd1, 8'h10);
    pulseEvt(0, 0, 0, 16'h0020, r);
    check("R4 pulse", r, 16'h0020);
    check("R3 masked irqN", irqN, 1);
    @(negedge clk); check("R4 single", reinitReq, 0);
    pulseEvt(0, 16'h0004, 0, 0, r);
    check("R4 disabled class", r, 0);
    regRead(6'd11, d); regRead(6'd10, d); regRead(6'd6, d);
    check("R5 dru lsb", d, 8'h04);
  endtask

  task automatic testSameCycle();
    logic [7:0] d; logic [15:0] r;
    pulseEvt(0, 16'h0002, 0, 0, r);
    @(negedge clk); addr = 6'd6; rdEn = 1'b1; druErrIn = 16'h0001;
    @(negedge clk); rdEn = 1'b0; druErrIn = '0; d = rdData;
    check("R9 old value", d, 8'h02);
    regRead(6'd6, d); check("R9 event kept", d, 8'h01);
  endtask

  task automatic testIgnored();
    logic [7:0] d; logic [15:0] r;
    regWrite(6'd0, 8'hFF); regWrite(6'd4, 8'hFF); regWrite(6'd11, 8'hFF);
    regRead(6'd0, d); check("R10 status write", d, 0);
    regRead(6'd4, d); check("R10 err write", d, 0);
    regRead(6'd11, d); check("R10 err write msb", d, 0);
    pulseEvt(16'h0100, 0, 0, 0, r);
    regRead(6'd3, d); check("R10 addr3", d, 0);
    regRead(6'd12, d); check("R10 addr12", d, 0);
    regRead(6'd63, d); check("R10 addr63", d, 0);
    regRead(6'd5, d); check("R5 clk msb", d, 8'h01);
    repeat (3) @(negedge clk);
    check("R11 hold", rdData, 8'h01);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCtlRegs();
    testCaptureAndIrq();
    testReinit();
    testSameCycle();
    testIgnored();
    finishRun();
  end
endmodule